// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns one high-level flash operation request into the exact series of 16-bit bus writes, and reads where needed, that a parallel NOR flash device accepts. Each access leaves through a single downstream port as an address/data pair. A valid/ready handshake governs that port, and there is never more than one access in flight. The supported operations are return-to-read, reset, identifier read, single-word program, buffered program, sector erase and whole-chip erase. Every operation except return-to-read opens with the two-write unlock preamble that the device requires.

For a buffered program, the block takes the words to store from a separate streaming input. It first sends a load command and the word count, then the words at consecutive addresses, then a confirm command. Program and erase operations end by starting an external status-polling block and reporting the code that block returns. The other operations finish as soon as their last access completes. A busy flag covers the whole operation, and requests that arrive while it is raised are dropped.

Top module: `norseq_engine`

## Requirements
- R1: Operation codes on `req_op` are 0 return-to-read, 1 reset, 2 identifier read, 3 word program, 4 buffered program, 5 sector erase and 6 chip erase. Every accepted operation except code 0 starts with two writes: 0x00AA to word address 0x555, then 0x0055 to word address 0x2AA.
- R2: Return-to-read issues exactly one write, 0x00F0 to address 0, with no unlock writes. Reset issues the unlock pair and then 0x00F0 to address 0.
- R3: Word program issues the unlock pair, then 0x00A0 to 0x555, then `req_word` to `req_addr`.
- R4: Sector erase issues the unlock pair, 0x0080 to 0x555, a second unlock pair, then 0x0030 to `req_addr`. Chip erase issues the same first five writes and then 0x0010 to 0x555.
- R5: Identifier read issues the unlock pair and 0x0090 to 0x555, then reads addresses 0x0, 0x1, 0xE and 0xF in that order. The data of each read appears once on `id_data`, with `id_valid` high for one cycle and `id_sel` set to 0, 1, 2 and 3 respectively.
- R6: Buffered program with count N issues the unlock pair, then 0x0025 to `req_addr`, then N-1 to `req_addr`. It then writes the N words taken in order from the load stream to `req_addr`+0 … `req_addr`+N-1, and ends with 0x0029 to `req_addr`+N-1. One stream word is consumed, with `ld_valid` and `ld_ready` both high, per data write.
- R7: A request is rejected if its op code is 7, or if it is a buffered program whose count is 0 or greater than MAX_BUF (32 by default). A rejected request finishes with result 3, issues no bus access and never raises `poll_start`.
- R8: Program and erase operations raise `poll_start` for one cycle after their last write completes. They then finish with `result` equal to `poll_code` (0 success, 1 device error, 2 timeout); a returned code of 3 is reported as 1. All other operations finish with result 0 and never raise `poll_start`.
- R9: `busy` rises in the cycle after a request is accepted and stays high through the single cycle in which `done` is high. `busy` is low in the following cycle. No bus access is pending while `busy` is low, and a request presented while `busy` is high is ignored.
- R10: Once `bus_valid` is raised, it stays high with `bus_write`, `bus_addr` and `bus_wdata` unchanged until the cycle in which `bus_ready` is high. A new access starts only after the previous one has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request strobe, sampled while idle |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | AW | Target, sector or buffer start word address |
| req_word | input | 16 | Data word for word program |
| req_count | input | CW | Word count for buffered program |
| busy | output | 1 | Operation in progress |
| ld_valid | input | 1 | Buffered-program stream word available |
| ld_data | input | 16 | Buffered-program stream word |
| ld_ready | output | 1 | Stream word taken this cycle when ld_valid is high |
| bus_valid | output | 1 | Downstream access request |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Access word address |
| bus_wdata | output | 16 | Write data |
| bus_ready | input | 1 | Access completes this cycle; read data valid |
| bus_rdata | input | 16 | Read data |
| poll_start | output | 1 | Start the status poller |
| poll_done | input | 1 | Poller finished |
| poll_code | input | 2 | Poller outcome |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2 | Completion code, valid with done |
| id_valid | output | 1 | Identifier word strobe |
| id_sel | output | 2 | Which identifier word |
| id_data | output | 16 | Identifier word |

## Verification
The assertions assume that the downstream memory raises `bus_ready` only while `bus_valid` is high, and that the poller raises `poll_done` only after it has seen `poll_start`. The bench's memory responder and poller answer only a pending access or a pending poll, each after a short pseudo-random delay. The stream source offers a word only while a buffered program still expects one, so the stream never runs ahead of the command sequence. Requests are driven only while the block is idle, except for one deliberate request made while busy to show that it is dropped.

// File: rtl/norseq_pkg.sv
`timescale 1ns/1ps
package norseq_pkg;

   localparam int unsigned WORD_W = 16;

   localparam logic [2:0] OP_TO_READ    = 3'd0;
   localparam logic [2:0] OP_RESET      = 3'd1;
   localparam logic [2:0] OP_READ_ID    = 3'd2;
   localparam logic [2:0] OP_WORD_PROG  = 3'd3;
   localparam logic [2:0] OP_BUF_PROG   = 3'd4;
   localparam logic [2:0] OP_SECT_ERASE = 3'd5;
   localparam logic [2:0] OP_CHIP_ERASE = 3'd6;
   localparam logic [2:0] OP_ILLEGAL    = 3'd7;

   localparam logic [1:0] RES_OK      = 2'd0;
   localparam logic [1:0] RES_DEV_ERR = 2'd1;
   localparam logic [1:0] RES_TIMEOUT = 2'd2;
   localparam logic [1:0] RES_REJECT  = 2'd3;

   localparam logic [11:0] ADR_KEY_A = 12'h555;
   localparam logic [11:0] ADR_KEY_B = 12'h2AA;

   localparam logic [15:0] DAT_KEY_A    = 16'h00AA;
   localparam logic [15:0] DAT_KEY_B    = 16'h0055;
   localparam logic [15:0] DAT_READ_ARR = 16'h00F0;
   localparam logic [15:0] DAT_AUTOSEL  = 16'h0090;
   localparam logic [15:0] DAT_PROG     = 16'h00A0;
   localparam logic [15:0] DAT_ERASE    = 16'h0080;
   localparam logic [15:0] DAT_SECTOR   = 16'h0030;
   localparam logic [15:0] DAT_CHIP     = 16'h0010;
   localparam logic [15:0] DAT_BUF_LOAD = 16'h0025;
   localparam logic [15:0] DAT_BUF_CONF = 16'h0029;

   typedef enum logic [1:0] {
      K_WRITE  = 2'd0,
      K_STREAM = 2'd1,
      K_READ   = 2'd2,
      K_END    = 2'd3
   } kind_e;

endpackage

// File: rtl/norseq_cmd_table.sv
`timescale 1ns/1ps
module norseq_cmd_table
   import norseq_pkg::*;
#(
   parameter int unsigned AW = 23,
   parameter int unsigned CW = 7,
   parameter int unsigned SW = 3
) (
   input  logic [2:0]        op,
   input  logic [SW-1:0]     step,
   input  logic [AW-1:0]     base,
   input  logic [CW-1:0]     count,
   input  logic [WORD_W-1:0] word,
   input  logic [CW-1:0]     idx,
   output kind_e             kind,
   output logic [AW-1:0]     addr,
   output logic [WORD_W-1:0] data
);

   localparam logic [AW-1:0] KA = AW'(ADR_KEY_A);
   localparam logic [AW-1:0] KB = AW'(ADR_KEY_B);

   logic [1:0]    id_rel;
   logic [AW-1:0] last_addr;

   assign id_rel    = 2'(step - SW'(3));
   assign last_addr = base + AW'(count) - AW'(1);

   always_comb begin
      kind = K_END;
      addr = '0;
      data = '0;
      if (op != OP_TO_READ && step == SW'(0)) begin
         kind = K_WRITE; addr = KA; data = DAT_KEY_A;
      end else if (op != OP_TO_READ && step == SW'(1)) begin
         kind = K_WRITE; addr = KB; data = DAT_KEY_B;
      end else begin
         case (op)
            OP_TO_READ: begin
               if (step == SW'(0)) begin
                  kind = K_WRITE; addr = '0; data = DAT_READ_ARR;
               end
            end
            OP_RESET: begin
               if (step == SW'(2)) begin
                  kind = K_WRITE; addr = '0; data = DAT_READ_ARR;
               end
            end
            OP_READ_ID: begin
               if (step == SW'(2)) begin
                  kind = K_WRITE; addr = KA; data = DAT_AUTOSEL;
               end else if (step >= SW'(3) && step <= SW'(6)) begin
                  kind = K_READ;
                  addr = AW'({id_rel[1], id_rel[1], id_rel[1], id_rel[0]});
               end
            end
            OP_WORD_PROG: begin
               if (step == SW'(2)) begin
                  kind = K_WRITE; addr = KA; data = DAT_PROG;
               end else if (step == SW'(3)) begin
                  kind = K_WRITE; addr = base; data = word;
               end
            end
            OP_BUF_PROG: begin
               case (step)
                  SW'(2): begin kind = K_WRITE; addr = base; data = DAT_BUF_LOAD; end
                  SW'(3): begin
                     kind = K_WRITE; addr = base;
                     data = WORD_W'(count - CW'(1));
                  end
                  SW'(4): begin kind = K_STREAM; addr = base + AW'(idx); end
                  SW'(5): begin kind = K_WRITE; addr = last_addr; data = DAT_BUF_CONF; end
                  default: ;
               endcase
            end
            OP_SECT_ERASE, OP_CHIP_ERASE: begin
               case (step)
                  SW'(2): begin kind = K_WRITE; addr = KA; data = DAT_ERASE; end
                  SW'(3): begin kind = K_WRITE; addr = KA; data = DAT_KEY_A; end
                  SW'(4): begin kind = K_WRITE; addr = KB; data = DAT_KEY_B; end
                  SW'(5): begin
                     kind = K_WRITE;
                     if (op == OP_SECT_ERASE) begin
                        addr = base; data = DAT_SECTOR;
                     end else begin
                        addr = KA; data = DAT_CHIP;
                     end
                  end
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/norseq_bus_issue.sv
`timescale 1ns/1ps
module norseq_bus_issue
   import norseq_pkg::*;
#(
   parameter int unsigned AW           = 23,
   parameter bit          ZERO_RD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ld_write,
   input  logic [AW-1:0]     ld_addr,
   input  logic [WORD_W-1:0] ld_wdata,
   input  logic              bus_ready,
   output logic              bus_valid,
   output logic              bus_write,
   output logic [AW-1:0]     bus_addr,
   output logic [WORD_W-1:0] bus_wdata,
   output logic              idle,
   output logic              fin
);

   logic              valid_q;
   logic              write_q;
   logic [AW-1:0]     addr_q;
   logic [WORD_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         write_q <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
      end else if (valid_q && bus_ready) begin
         valid_q <= 1'b0;
      end else if (load && !valid_q) begin
         valid_q <= 1'b1;
         write_q <= ld_write;
         addr_q  <= ld_addr;
         data_q  <= ld_wdata;
      end
   end

   assign bus_valid = valid_q;
   assign bus_write = write_q;
   assign bus_addr  = addr_q;
   assign idle      = !valid_q;
   assign fin       = valid_q && bus_ready;

   generate
      if (ZERO_RD_DATA) begin : g_rd_zero
         assign bus_wdata = write_q ? data_q : '0;
      end else begin : g_rd_hold
         assign bus_wdata = data_q;
      end
   endgenerate

   // R10: a pending access holds its fields until it is accepted
   a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                 && $stable(bus_wdata) && $stable(bus_write));

   // R10: the sequencer never offers a new access while one is pending
   a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !bus_valid);

endmodule

// File: rtl/norseq_engine.sv
`timescale 1ns/1ps
module norseq_engine
   import norseq_pkg::*;
#(
   parameter int unsigned AW           = 23,
   parameter int unsigned MAX_BUF      = 32,
   parameter bit          ZERO_RD_DATA = 1'b1,
   localparam int unsigned CW          = $clog2(MAX_BUF + 1) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [AW-1:0]     req_addr,
   input  logic [15:0]       req_word,
   input  logic [CW-1:0]     req_count,
   output logic              busy,
   input  logic              ld_valid,
   input  logic [15:0]       ld_data,
   output logic              ld_ready,
   output logic              bus_valid,
   output logic              bus_write,
   output logic [AW-1:0]     bus_addr,
   output logic [15:0]       bus_wdata,
   input  logic              bus_ready,
   input  logic [15:0]       bus_rdata,
   output logic              poll_start,
   input  logic              poll_done,
   input  logic [1:0]        poll_code,
   output logic              done,
   output logic [1:0]        result,
   output logic              id_valid,
   output logic [1:0]        id_sel,
   output logic [15:0]       id_data
);

   localparam int unsigned SW = 3;

   initial begin : a_cfg_checks
      assert (AW >= 12) else $error("address width must hold the unlock addresses");
      assert (MAX_BUF >= 1 && MAX_BUF <= 65536) else $error("buffer limit out of range");
   end

   typedef enum logic [2:0] {
      S_IDLE      = 3'd0,
      S_RUN       = 3'd1,
      S_POLL_REQ  = 3'd2,
      S_POLL_WAIT = 3'd3,
      S_DONE      = 3'd4
   } st_e;

   st_e           state;
   logic [2:0]    op_q;
   logic [AW-1:0] base_q;
   logic [CW-1:0] count_q;
   logic [15:0]   word_q;
   logic [SW-1:0] step_q;
   logic [CW-1:0] idx_q;
   logic [1:0]    res_q;
   logic          idv_q;
   logic [1:0]    ids_q;
   logic [15:0]   idd_q;

   kind_e         kind;
   logic [AW-1:0] t_addr;
   logic [15:0]   t_data;
   logic          iss_idle;
   logic          iss_fin;
   logic          load;
   logic          reject;
   logic          needs_poll;
   logic          last_stream;

   norseq_cmd_table #(.AW(AW), .CW(CW), .SW(SW)) u_table (
      .op    (op_q),
      .step  (step_q),
      .base  (base_q),
      .count (count_q),
      .word  (word_q),
      .idx   (idx_q),
      .kind  (kind),
      .addr  (t_addr),
      .data  (t_data)
   );

   assign load     = (state == S_RUN) && iss_idle && (kind != K_END)
                     && ((kind != K_STREAM) || ld_valid);
   assign ld_ready = (state == S_RUN) && iss_idle && (kind == K_STREAM);

   norseq_bus_issue #(.AW(AW), .ZERO_RD_DATA(ZERO_RD_DATA)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .ld_write  (kind != K_READ),
      .ld_addr   (t_addr),
      .ld_wdata  ((kind == K_STREAM) ? ld_data : t_data),
      .bus_ready (bus_ready),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .idle      (iss_idle),
      .fin       (iss_fin)
   );

   assign reject = (req_op == OP_ILLEGAL)
                   || ((req_op == OP_BUF_PROG)
                       && ((req_count == '0) || (req_count > CW'(MAX_BUF))));
   assign needs_poll = (op_q == OP_WORD_PROG) || (op_q == OP_BUF_PROG)
                       || (op_q == OP_SECT_ERASE) || (op_q == OP_CHIP_ERASE);
   assign last_stream = (idx_q == count_q - CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         op_q    <= OP_TO_READ;
         base_q  <= '0;
         count_q <= '0;
         word_q  <= '0;
         step_q  <= '0;
         idx_q   <= '0;
         res_q   <= RES_OK;
         idv_q   <= 1'b0;
         ids_q   <= '0;
         idd_q   <= '0;
      end else begin
         idv_q <= 1'b0;
         case (state)
            S_IDLE: begin
               if (req_valid) begin
                  op_q    <= req_op;
                  base_q  <= req_addr;
                  count_q <= req_count;
                  word_q  <= req_word;
                  step_q  <= '0;
                  idx_q   <= '0;
                  if (reject) begin
                     res_q <= RES_REJECT;
                     state <= S_DONE;
                  end else begin
                     res_q <= RES_OK;
                     state <= S_RUN;
                  end
               end
            end
            S_RUN: begin
               if (iss_fin) begin
                  if (kind == K_STREAM && !last_stream) begin
                     idx_q <= idx_q + CW'(1);
                  end else begin
                     step_q <= step_q + SW'(1);
                  end
                  if (kind == K_READ) begin
                     idv_q <= 1'b1;
                     ids_q <= 2'(step_q - SW'(3));
                     idd_q <= bus_rdata;
                  end
               end else if (iss_idle && kind == K_END) begin
                  state <= needs_poll ? S_POLL_REQ : S_DONE;
               end
            end
            S_POLL_REQ: state <= S_POLL_WAIT;
            S_POLL_WAIT: begin
               if (poll_done) begin
                  res_q <= (poll_code == RES_REJECT) ? RES_DEV_ERR : poll_code;
                  state <= S_DONE;
               end
            end
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy       = (state != S_IDLE);
   assign done       = (state == S_DONE);
   assign poll_start = (state == S_POLL_REQ);
   assign result     = res_q;
   assign id_valid   = idv_q;
   assign id_sel     = ids_q;
   assign id_data    = idd_q;

   // R9: nothing reaches the bus while the block is idle
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_valid);

   // R9: completion strobe lasts a single cycle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R7: a rejected request leaves the bus untouched
   a_r7_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
      done && result == RES_REJECT |-> !bus_valid && !$past(bus_valid));

   // R6: a stream word is taken only when no access is pending
   a_r6_stream_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ready |-> !bus_valid);

   // R8: the poller starts only after the last access has completed
   a_r8_poll_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
      poll_start |-> !bus_valid && !done);

   // R5: identifier words appear only during an identifier read
   a_r5_id_in_op: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |-> busy && op_q == OP_READ_ID);

endmodule

// File: tb/norseq_engine_test.sv
`timescale 1ns/1ps
module norseq_engine_test;

   localparam int AW = 23;
   localparam int CW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0]   req_word = '0;
   logic [CW-1:0] req_count = '0;
   logic          busy;
   logic          ld_valid;
   logic [15:0]   ld_data;
   logic          ld_ready;
   logic          bus_valid, bus_write;
   logic [AW-1:0] bus_addr;
   logic [15:0]   bus_wdata;
   logic          bus_ready;
   logic [15:0]   bus_rdata;
   logic          poll_start;
   logic          poll_done;
   logic [1:0]    poll_code;
   logic          done;
   logic [1:0]    result;
   logic          id_valid;
   logic [1:0]    id_sel;
   logic [15:0]   id_data;

   norseq_engine uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_word(req_word), .req_count(req_count),
      .busy(busy), .ld_valid(ld_valid), .ld_data(ld_data), .ld_ready(ld_ready),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .poll_start(poll_start), .poll_done(poll_done), .poll_code(poll_code),
      .done(done), .result(result), .id_valid(id_valid), .id_sel(id_sel),
      .id_data(id_data)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int n_polls = 0;
   int unsigned lfsr = 32'h1234_5678;
   logic [1:0] poll_rsp = 2'd0;
   string cur_req = "R1";

   int exp_wr[$];
   int exp_addr[$];
   int exp_data[$];
   int stream_q[$];
   int id_q[$];

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int next_delay();
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      return int'((lfsr >> 16) % 3);
   endfunction

   function automatic int rd_value(input int a);
      return (16'h5A00 ^ a) & 16'hFFFF;
   endfunction

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         report();
      end
   end

   // memory responder and bus comparison against the reference sequence (R10)
   initial begin
      int dly;
      bus_ready = 1'b0;
      bus_rdata = '0;
      dly = next_delay();
      forever begin
         @(negedge clk);
         if (bus_valid && !bus_ready) begin
            if (dly > 0) dly--;
            else begin
               checks++;
               if (exp_wr.size() == 0) begin
                  fails++;
                  $display("FAIL %s unexpected access: actual wr=%0d addr=%0h data=%0h expected none",
                           cur_req, bus_write, bus_addr, bus_wdata);
               end else begin
                  if (int'(bus_write) != exp_wr[0] || int'(bus_addr) != exp_addr[0]
                      || (exp_wr[0] == 1 && int'(bus_wdata) != exp_data[0])) begin
                     fails++;
                     $display("FAIL %s access: actual wr=%0d addr=%0h data=%0h expected wr=%0d addr=%0h data=%0h",
                              cur_req, bus_write, bus_addr, bus_wdata,
                              exp_wr[0], exp_addr[0], exp_data[0]);
                  end
                  void'(exp_wr.pop_front());
                  void'(exp_addr.pop_front());
                  void'(exp_data.pop_front());
               end
               bus_ready = 1'b1;
               bus_rdata = bus_write ? 16'h0 : 16'(rd_value(int'(bus_addr)));
               @(posedge clk);
               #1 bus_ready = 1'b0;
               dly = next_delay();
            end
         end
      end
   end

   // buffered-program stream source (R6)
   initial begin
      ld_valid = 1'b0;
      ld_data  = '0;
      forever begin
         @(negedge clk);
         ld_valid = (stream_q.size() > 0);
         ld_data  = (stream_q.size() > 0) ? 16'(stream_q[0]) : 16'h0;
         if (ld_valid && ld_ready) begin
            @(posedge clk);
            #1 void'(stream_q.pop_front());
         end
      end
   end

   // status poller (R8)
   initial begin
      poll_done = 1'b0;
      poll_code = '0;
      forever begin
         @(negedge clk);
         if (poll_start) begin
            n_polls++;
            repeat (3) @(negedge clk);
            poll_done = 1'b1;
            poll_code = poll_rsp;
            @(posedge clk);
            #1 poll_done = 1'b0;
         end
      end
   end

   // identifier word monitor (R5)
   initial begin
      forever begin
         @(negedge clk);
         if (id_valid) begin
            if (id_q.size() == 0) begin
               check(1'b0, "R5", "unexpected id word", int'(id_data), 0);
            end else begin
               check({16'h0, 14'h0, id_sel, id_data} == id_q[0], "R5", "id sel/data",
                     int'({id_sel, id_data}), id_q[0]);
               void'(id_q.pop_front());
            end
         end
      end
   end

   // idle bus check on every clock (R9)
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) check(busy || !bus_valid, "R9", "bus active while idle",
                          int'(bus_valid), 0);
      end
   end

   task automatic push_w(input int a, input int d);
      exp_wr.push_back(1); exp_addr.push_back(a); exp_data.push_back(d);
   endtask

   task automatic push_r(input int a);
      exp_wr.push_back(0); exp_addr.push_back(a); exp_data.push_back(0);
   endtask

   task automatic unlock();
      push_w('h555, 'h00AA);
      push_w('h2AA, 'h0055);
   endtask

   task automatic run_op(input int op, input int a, input int w, input int n,
                         input logic [1:0] rsp, input int exp_res,
                         input string tag, input bit inject);
      int exp_polls;
      bit rej;
      int wait_n;
      cur_req  = tag;
      poll_rsp = rsp;
      n_polls  = 0;
      rej = (op == 7) || (op == 4 && (n == 0 || n > 32));
      exp_polls = (!rej && op >= 3 && op <= 6) ? 1 : 0;
      if (!rej) begin
         case (op)
            0: push_w(0, 'h00F0);
            1: begin unlock(); push_w(0, 'h00F0); end
            2: begin
               int ida[4] = '{'h0, 'h1, 'hE, 'hF};
               unlock(); push_w('h555, 'h0090);
               for (int k = 0; k < 4; k++) begin
                  push_r(ida[k]);
                  id_q.push_back((k << 16) | rd_value(ida[k]));
               end
            end
            3: begin unlock(); push_w('h555, 'h00A0); push_w(a, w); end
            4: begin
               unlock(); push_w(a, 'h0025); push_w(a, n - 1);
               for (int i = 0; i < n; i++) begin
                  int v = (w + i * 'h0101) & 'hFFFF;
                  stream_q.push_back(v);
                  push_w(a + i, v);
               end
               push_w(a + n - 1, 'h0029);
            end
            5, 6: begin
               unlock(); push_w('h555, 'h0080); unlock();
               if (op == 5) push_w(a, 'h0030); else push_w('h555, 'h0010);
            end
            default: ;
         endcase
      end
      @(posedge clk);
      #1;
      req_valid = 1'b1; req_op = 3'(op); req_addr = AW'(a);
      req_word = 16'(w); req_count = CW'(n);
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
      if (inject) begin
         @(posedge clk);
         #1;
         req_valid = 1'b1; req_op = 3'd6; req_addr = '0;
         @(posedge clk);
         #1 req_valid = 1'b0;
         @(negedge clk);
      end
      wait_n = 0;
      while (!done && wait_n < 3000) begin
         @(negedge clk);
         wait_n++;
      end
      check(done == 1'b1, tag, "completion seen", int'(done), 1);
      check(busy == 1'b1, "R9", "busy during done", int'(busy), 1);
      check(int'(result) == exp_res, tag, "result", int'(result), exp_res);
      check(exp_wr.size() == 0, tag, "accesses left over", exp_wr.size(), 0);
      check(stream_q.size() == 0, "R6", "stream words left", stream_q.size(), 0);
      check(id_q.size() == 0, "R5", "id words left", id_q.size(), 0);
      check(n_polls == exp_polls, "R8", "poll starts", n_polls, exp_polls);
      @(negedge clk);
      check(busy == 1'b0, "R9", "busy after done", int'(busy), 0);
      if (inject) begin
         repeat (12) @(negedge clk);
         check(!busy && !bus_valid, "R9", "request while busy ignored",
               int'({busy, bus_valid}), 0);
      end
      exp_wr.delete(); exp_addr.delete(); exp_data.delete();
      stream_q.delete(); id_q.delete();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!busy && !bus_valid && !done && !poll_start && !ld_ready,
            "R9", "reset state", int'({busy, bus_valid, done, poll_start, ld_ready}), 0);
      #1 rst_n = 1'b1;
      run_op(0, 0, 0, 0, 2'd0, 0, "R2", 1'b0);
      run_op(1, 0, 0, 0, 2'd0, 0, "R1", 1'b0);
      run_op(2, 0, 0, 0, 2'd0, 0, "R5", 1'b0);
      run_op(3, 'h12345, 'hBEEF, 0, 2'd0, 0, "R3", 1'b0);
      run_op(5, 'h40000, 0, 0, 2'd1, 1, "R4", 1'b0);
      run_op(6, 0, 0, 0, 2'd2, 2, "R4", 1'b0);
      run_op(6, 0, 0, 0, 2'd3, 1, "R8", 1'b0);
      run_op(4, 'h2000, 'h1111, 1, 2'd0, 0, "R6", 1'b0);
      run_op(4, 'h3000, 'h0A0B, 5, 2'd0, 0, "R6", 1'b0);
      run_op(4, 'h7FFE0, 'h4321, 32, 2'd2, 2, "R6", 1'b0);
      run_op(4, 'h100, 'h1, 0, 2'd0, 3, "R7", 1'b0);
      run_op(4, 'h100, 'h1, 33, 2'd0, 3, "R7", 1'b0);
      run_op(7, 'h100, 'h1, 0, 2'd0, 3, "R7", 1'b0);
      run_op(3, 'h0ABC, 'h5555, 0, 2'd0, 0, "R3", 1'b1);
      repeat (5) @(posedge clk);
      report();
   end

endmodule